// File: doc/BRIEF.md
# Microcode Line Sequencer

The sequencer steps through a small writable store of wide issue lines and presents one line per clock to a row of functional units. Each line carries an operation code and a result-destination code for every unit, and ends in a control field that the sequencer itself consumes. That control field can hold the current line in place for a number of cycles, close a loop body by jumping back to a target line a set number of times, or stop the sequencer. Loop bookkeeping lives in a small stack of end-line addresses and remaining-jump counts. Because of this stack, nested loops cost no extra cycles.

A host fills the line store and a bank of loop-count registers while the sequencer is idle. It then pulses start with an entry address. From then on the schedule alone decides timing. Nothing in the block checks data dependencies or resource hazards between units.

Line layout, from bit 0 upward: count field (CNT_W bits), target address (ADDR_W bits), control code (3 bits), then one OP_W+DST_W slice per unit. In each slice the operation sits in the low OP_W bits. Control codes are: 0 none, 1 hold, 2 loop with immediate count, 3 loop with register count, 4 stop. Codes 5 to 7 behave as none.

Top module: `microcode_seq`

## Requirements
- R1: After reset, issue_valid, busy and done are all 0.
- R2: A start pulse while idle sets busy at the next edge and loads the fetch address from start_addr. Each following cycle issues one line (issue_valid=1, issue_addr = its address). The address advances by one per line and wraps from the last line to line 0.
- R3: In each issued line, fu_op and fu_dst together present the operation slice and destination slice of every unit, all taken from the line at issue_addr.
- R4: A hold line (code 1) with count N issues max(N,1) times in consecutive cycles before the next line issues.
- R5: A loop line with immediate count C (code 2) jumps to the target address C times and then falls through. C=0 falls through at once.
- R6: A loop line with code 3 takes its count from the count register selected by the low log2(NUM_KREG) bits of the count field. Otherwise it behaves as R5.
- R7: Loops nest up to STACK_DEPTH levels. A loop line is recognised as the active one when its address equals the end address on top of the stack.
- R8: A stop line (code 4) is not issued. At that edge, busy and issue_valid drop and done rises. done stays 1 until the next accepted start.
- R9: Host writes to the line store or to the count registers, and start pulses, have no effect while busy.
- R10: A new loop met with the stack full falls through without jumping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_line_we | input | 1 | Write one line into the store (idle only) |
| host_line_addr | input | ADDR_W | Line index to write |
| host_line_data | input | LINE_W | Line contents |
| host_kreg_we | input | 1 | Write one loop-count register (idle only) |
| host_kreg_idx | input | KIDX_W | Count register index |
| host_kreg_data | input | CNT_W | Count value |
| start_i | input | 1 | Start pulse, honoured only while idle |
| start_addr | input | ADDR_W | First line to issue |
| issue_valid | output | 1 | A line is being issued this cycle |
| issue_addr | output | ADDR_W | Address of the issued line |
| fu_op | output | NUM_FU*OP_W | Operation codes, unit 0 in the low bits |
| fu_dst | output | NUM_FU*DST_W | Result destinations, unit 0 in the low bits |
| busy | output | 1 | Sequencer is fetching and issuing |
| done | output | 1 | Last run ended on a stop line |

## Verification
Several sequencer functions can land in the same cycle. The stop line retiring can coincide with a start pulse, and the bench holds start high across that edge. The start must be ignored: done must end up high with busy low, and no second run may follow. Host writes are also held active through a whole run, so an attempted store or count-register update lands in cycles where loop jumps and holds are taking place. A later run must show the original fields and counts. A cycle-accurate behavioural model compares every output on every clock, and per-scenario issue totals are set against hand-derived counts, including the 92-line overflow case.

// File: rtl/microcode_seq_pkg.sv
package microcode_seq_pkg;
  typedef enum logic [2:0] {
    CTL_NONE     = 3'd0,
    CTL_HOLD     = 3'd1,
    CTL_LOOP_IMM = 3'd2,
    CTL_LOOP_REG = 3'd3,
    CTL_STOP     = 3'd4
  } ctl_code_e;

  localparam int CTL_CODE_W = 3;

  function automatic logic code_is_loop(input logic [CTL_CODE_W-1:0] c);
    return (c == CTL_LOOP_IMM) || (c == CTL_LOOP_REG);
  endfunction

  function automatic logic code_is_hold(input logic [CTL_CODE_W-1:0] c);
    return c == CTL_HOLD;
  endfunction

  function automatic logic code_is_stop(input logic [CTL_CODE_W-1:0] c);
    return c == CTL_STOP;
  endfunction
endpackage

// File: rtl/microcode_seq_store.sv
module microcode_seq_store #(
  parameter int ADDR_W = 5,
  parameter int LINE_W = 44
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LINE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LINE_W-1:0] rdata
);
  localparam int LINES = 1 << ADDR_W;

  logic [LINE_W-1:0] lines_q [LINES];

  always_ff @(posedge clk) begin
    if (we) lines_q[waddr] <= wdata;
  end

  assign rdata = lines_q[raddr];
endmodule

// File: rtl/microcode_seq_stack.sv
module microcode_seq_stack #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 8,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [CNT_W-1:0]  push_cnt,
  input  logic              pop,
  input  logic              dec,
  output logic              top_valid,
  output logic [ADDR_W-1:0] top_addr,
  output logic [CNT_W-1:0]  top_cnt,
  output logic              full,
  output logic [SP_W-1:0]   depth
);
  logic [ADDR_W-1:0] end_q [DEPTH];
  logic [CNT_W-1:0]  left_q [DEPTH];
  logic [SP_W-1:0]   sp_q;
  logic [SP_W-1:0]   top_full;
  logic [IDX_W-1:0]  top_idx;
  logic [IDX_W-1:0]  push_idx;

  assign top_full  = sp_q - SP_W'(1);
  assign top_idx   = top_full[IDX_W-1:0];
  assign push_idx  = sp_q[IDX_W-1:0];
  assign top_valid = (sp_q != '0);
  assign full      = (sp_q == SP_W'(DEPTH));
  assign top_addr  = end_q[top_idx];
  assign top_cnt   = left_q[top_idx];
  assign depth     = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (clear) begin
      sp_q <= '0;
    end else if (push && !full) begin
      sp_q <= sp_q + SP_W'(1);
    end else if (pop && top_valid) begin
      sp_q <= sp_q - SP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!clear && push && !full) begin
      end_q[push_idx]  <= push_addr;
      left_q[push_idx] <= push_cnt;
    end else if (!clear && dec && top_valid) begin
      left_q[top_idx] <= top_cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/microcode_seq_next.sv
module microcode_seq_next
  import microcode_seq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic                  running,
  input  logic [ADDR_W-1:0]     pc,
  input  logic [CTL_CODE_W-1:0] code,
  input  logic [ADDR_W-1:0]     target,
  input  logic [CNT_W-1:0]      imm_cnt,
  input  logic [CNT_W-1:0]      reg_cnt,
  input  logic                  hold_active,
  input  logic [CNT_W-1:0]      hold_left,
  input  logic                  top_valid,
  input  logic [ADDR_W-1:0]     top_addr,
  input  logic [CNT_W-1:0]      top_cnt,
  input  logic                  stack_full,
  output logic [ADDR_W-1:0]     next_pc,
  output logic                  stay,
  output logic                  jump,
  output logic                  push,
  output logic                  pop,
  output logic                  dec,
  output logic                  stop,
  output logic                  hold_active_d,
  output logic [CNT_W-1:0]      hold_left_d
);
  logic [CNT_W-1:0] loop_cnt;
  logic             loop_match;

  assign loop_cnt   = (code == CTL_LOOP_REG) ? reg_cnt : imm_cnt;
  assign loop_match = top_valid && (top_addr == pc);
  assign stop       = running && code_is_stop(code);

  always_comb begin
    stay          = 1'b0;
    jump          = 1'b0;
    push          = 1'b0;
    pop           = 1'b0;
    dec           = 1'b0;
    hold_active_d = 1'b0;
    hold_left_d   = '0;
    if (running && code_is_hold(code)) begin
      if (hold_active) begin
        if (hold_left != '0) begin
          stay          = 1'b1;
          hold_active_d = 1'b1;
          hold_left_d   = hold_left - CNT_W'(1);
        end
      end else if (imm_cnt > CNT_W'(1)) begin
        stay          = 1'b1;
        hold_active_d = 1'b1;
        hold_left_d   = imm_cnt - CNT_W'(2);
      end
    end else if (running && code_is_loop(code)) begin
      if (loop_match) begin
        if (top_cnt == '0) begin
          pop = 1'b1;
        end else begin
          dec  = 1'b1;
          jump = 1'b1;
        end
      end else if (loop_cnt != '0 && !stack_full) begin
        push = 1'b1;
        jump = 1'b1;
      end
    end
  end

  always_comb begin
    if (stay)      next_pc = pc;
    else if (jump) next_pc = target;
    else           next_pc = pc + ADDR_W'(1);
  end
endmodule

// File: rtl/microcode_seq.sv
module microcode_seq
  import microcode_seq_pkg::*;
#(
  parameter int NUM_FU      = 4,
  parameter int OP_W        = 4,
  parameter int DST_W       = 3,
  parameter int ADDR_W      = 5,
  parameter int CNT_W       = 8,
  parameter int STACK_DEPTH = 4,
  parameter int NUM_KREG    = 4,
  localparam int KIDX_W     = (NUM_KREG > 1) ? $clog2(NUM_KREG) : 1,
  localparam int FU_W       = OP_W + DST_W,
  localparam int TGT_LSB    = CNT_W,
  localparam int CODE_LSB   = CNT_W + ADDR_W,
  localparam int FU_LSB     = CODE_LSB + CTL_CODE_W,
  localparam int LINE_W     = FU_LSB + NUM_FU * FU_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_line_we,
  input  logic [ADDR_W-1:0]       host_line_addr,
  input  logic [LINE_W-1:0]       host_line_data,
  input  logic                    host_kreg_we,
  input  logic [KIDX_W-1:0]       host_kreg_idx,
  input  logic [CNT_W-1:0]        host_kreg_data,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       start_addr,
  output logic                    issue_valid,
  output logic [ADDR_W-1:0]       issue_addr,
  output logic [NUM_FU*OP_W-1:0]  fu_op,
  output logic [NUM_FU*DST_W-1:0] fu_dst,
  output logic                    busy,
  output logic                    done
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);

  logic                  running_q, done_q;
  logic [ADDR_W-1:0]     pc_q;
  logic                  hold_active_q;
  logic [CNT_W-1:0]      hold_left_q;
  logic [CNT_W-1:0]      kreg_q [NUM_KREG];
  logic                  valid_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [LINE_W-1:0]     line_q;

  logic [LINE_W-1:0]     cur_line;
  logic [CTL_CODE_W-1:0] cur_code;
  logic [ADDR_W-1:0]     cur_tgt;
  logic [CNT_W-1:0]      cur_cnt;
  logic [CNT_W-1:0]      reg_cnt;

  logic                  store_we;
  logic                  accept_start;
  logic                  hold_line;
  logic                  jump_taken;
  logic                  stk_push, stk_pop, stk_dec;
  logic                  stop_line;
  logic                  stk_top_valid, stk_full;
  logic [ADDR_W-1:0]     stk_top_addr;
  logic [CNT_W-1:0]      stk_top_cnt;
  logic [SP_W-1:0]       stk_depth;
  logic [ADDR_W-1:0]     next_pc;
  logic                  hold_active_d;
  logic [CNT_W-1:0]      hold_left_d;

  assign store_we     = host_line_we && !running_q;
  assign accept_start = start_i && !running_q;

  assign cur_code = cur_line[CODE_LSB +: CTL_CODE_W];
  assign cur_tgt  = cur_line[TGT_LSB +: ADDR_W];
  assign cur_cnt  = cur_line[0 +: CNT_W];
  assign reg_cnt  = kreg_q[cur_cnt[KIDX_W-1:0]];

  microcode_seq_store #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
    .clk   (clk),
    .we    (store_we),
    .waddr (host_line_addr),
    .wdata (host_line_data),
    .raddr (pc_q),
    .rdata (cur_line)
  );

  microcode_seq_stack #(.DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept_start),
    .push      (stk_push),
    .push_addr (pc_q),
    .push_cnt  (((cur_code == CTL_LOOP_REG) ? reg_cnt : cur_cnt) - CNT_W'(1)),
    .pop       (stk_pop),
    .dec       (stk_dec),
    .top_valid (stk_top_valid),
    .top_addr  (stk_top_addr),
    .top_cnt   (stk_top_cnt),
    .full      (stk_full),
    .depth     (stk_depth)
  );

  microcode_seq_next #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_next (
    .running       (running_q),
    .pc            (pc_q),
    .code          (cur_code),
    .target        (cur_tgt),
    .imm_cnt       (cur_cnt),
    .reg_cnt       (reg_cnt),
    .hold_active   (hold_active_q),
    .hold_left     (hold_left_q),
    .top_valid     (stk_top_valid),
    .top_addr      (stk_top_addr),
    .top_cnt       (stk_top_cnt),
    .stack_full    (stk_full),
    .next_pc       (next_pc),
    .stay          (hold_line),
    .jump          (jump_taken),
    .push          (stk_push),
    .pop           (stk_pop),
    .dec           (stk_dec),
    .stop          (stop_line),
    .hold_active_d (hold_active_d),
    .hold_left_d   (hold_left_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_KREG; k++) kreg_q[k] <= '0;
    end else if (host_kreg_we && !running_q) begin
      kreg_q[host_kreg_idx] <= host_kreg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q     <= 1'b0;
      done_q        <= 1'b0;
      pc_q          <= '0;
      hold_active_q <= 1'b0;
      hold_left_q   <= '0;
      valid_q       <= 1'b0;
      addr_q        <= '0;
      line_q        <= '0;
    end else if (!running_q) begin
      valid_q <= 1'b0;
      if (accept_start) begin
        running_q     <= 1'b1;
        done_q        <= 1'b0;
        pc_q          <= start_addr;
        hold_active_q <= 1'b0;
        hold_left_q   <= '0;
      end
    end else if (stop_line) begin
      running_q     <= 1'b0;
      done_q        <= 1'b1;
      valid_q       <= 1'b0;
      hold_active_q <= 1'b0;
    end else begin
      valid_q       <= 1'b1;
      addr_q        <= pc_q;
      line_q        <= cur_line;
      pc_q          <= next_pc;
      hold_active_q <= hold_active_d;
      hold_left_q   <= hold_left_d;
    end
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    assign fu_op[u*OP_W +: OP_W]    = line_q[FU_LSB + u*FU_W +: OP_W];
    assign fu_dst[u*DST_W +: DST_W] = line_q[FU_LSB + u*FU_W + OP_W +: DST_W];
  end

  assign issue_valid = valid_q;
  assign issue_addr  = addr_q;
  assign busy        = running_q;
  assign done        = done_q;
endmodule

// File: rtl/microcode_seq_chk.sv
module microcode_seq_chk #(
  parameter int ADDR_W      = 5,
  parameter int STACK_DEPTH = 4,
  parameter int SP_W        = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              issue_valid,
  input logic              hold_line,
  input logic [ADDR_W-1:0] pc_q,
  input logic [SP_W-1:0]   stk_depth,
  input logic              stk_push,
  input logic              stk_pop
);
  // R8: leaving the busy state is always caused by a stop line
  a_r8_fall_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8: done and busy never overlap
  a_r8_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R2: an issued line was fetched while the sequencer was running
  a_r2_issue_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> $past(busy));

  // R4: a held line keeps the fetch address for the next cycle
  a_r4_hold_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold_line) |=> $stable(pc_q));

  // R10: the loop stack never grows past its depth
  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= SP_W'(STACK_DEPTH));

  // R7: a loop line either enters or leaves a level, never both
  a_r7_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_push && stk_pop));
endmodule

bind microcode_seq microcode_seq_chk #(
  .ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH), .SP_W(SP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .issue_valid (issue_valid),
  .hold_line   (hold_line),
  .pc_q        (pc_q),
  .stk_depth   (stk_depth),
  .stk_push    (stk_push),
  .stk_pop     (stk_pop)
);

// File: tb/microcode_seq_bench.sv
`timescale 1ns/1ps
module microcode_seq_bench;
  localparam int NUM_FU = 4, OP_W = 4, DST_W = 3, ADDR_W = 5, CNT_W = 8;
  localparam int DEPTH = 4, NK = 4, KIDX_W = 2;
  localparam int LINE_W = CNT_W + ADDR_W + 3 + NUM_FU * (OP_W + DST_W);
  localparam int LINES = 32;

  logic clk = 0, rst_n = 0;
  logic host_line_we = 0, host_kreg_we = 0, start_i = 0;
  logic [ADDR_W-1:0] host_line_addr = '0, start_addr = '0;
  logic [LINE_W-1:0] host_line_data = '0;
  logic [KIDX_W-1:0] host_kreg_idx = '0;
  logic [CNT_W-1:0]  host_kreg_data = '0;
  logic issue_valid, busy, done;
  logic [ADDR_W-1:0] issue_addr;
  logic [NUM_FU*OP_W-1:0]  fu_op;
  logic [NUM_FU*DST_W-1:0] fu_dst;

  always #10 clk = ~clk;

  microcode_seq u_microcode_seq (
    .clk, .rst_n, .host_line_we, .host_line_addr, .host_line_data,
    .host_kreg_we, .host_kreg_idx, .host_kreg_data, .start_i, .start_addr,
    .issue_valid, .issue_addr, .fu_op, .fu_dst, .busy, .done);

  int checks = 0, errors = 0, cycles = 0;
  int n_issue = 0;
  int per_addr [LINES];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model state
  logic [LINE_W-1:0] ref_mem [LINES];
  int kref [NK];
  int m_run = 0, m_done = 0, m_pc = 0, m_hold_act = 0, m_hold_left = 0;
  int s_end[$], s_left[$];
  int e_valid = 0, e_addr = 0;
  logic [LINE_W-1:0] e_line = '0;

  function automatic logic [LINE_W-1:0] mk(input int code, input int tgt, input int cnt, input int seed);
    logic [LINE_W-1:0] l;
    logic [31:0] h;
    h = 32'(seed) * 32'h9E3779B1 + 32'h1234567;
    l = '0;
    l[LINE_W-1:16] = h[27:0];
    l[15:13] = 3'(code);
    l[12:8]  = 5'(tgt);
    l[7:0]   = 8'(cnt);
    return l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_pc = 0; e_valid = 0; m_hold_act = 0;
      s_end.delete(); s_left.delete();
      for (int k = 0; k < NK; k++) kref[k] = 0;
    end else if (!m_run) begin
      e_valid = 0;
      if (host_line_we) ref_mem[host_line_addr] = host_line_data;
      if (host_kreg_we) kref[host_kreg_idx] = host_kreg_data;
      if (start_i) begin
        m_run = 1; m_done = 0; m_pc = start_addr; m_hold_act = 0;
        s_end.delete(); s_left.delete();
      end
    end else begin
      logic [LINE_W-1:0] ln;
      int code, tgt, cnt, c;
      ln = ref_mem[m_pc];
      code = ln[15:13]; tgt = ln[12:8]; cnt = ln[7:0];
      if (code == 4) begin
        m_run = 0; m_done = 1; e_valid = 0;
      end else begin
        e_valid = 1; e_addr = m_pc; e_line = ln;
        if (code == 1) begin
          if (!m_hold_act) m_hold_left = (cnt == 0) ? 1 : cnt;
          m_hold_left--;
          if (m_hold_left > 0) m_hold_act = 1;
          else begin m_hold_act = 0; m_pc = (m_pc + 1) % LINES; end
        end else if (code == 2 || code == 3) begin
          c = (code == 2) ? cnt : kref[cnt % NK];
          if (s_end.size() > 0 && s_end[$] == m_pc) begin
            if (s_left[$] == 0) begin
              void'(s_end.pop_back()); void'(s_left.pop_back());
              m_pc = (m_pc + 1) % LINES;
            end else begin
              s_left[$] = s_left[$] - 1; m_pc = tgt;
            end
          end else if (c > 0 && s_end.size() < DEPTH) begin
            s_end.push_back(m_pc); s_left.push_back(c - 1); m_pc = tgt;
          end else m_pc = (m_pc + 1) % LINES;
        end else m_pc = (m_pc + 1) % LINES;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(issue_valid == e_valid[0], "R2 valid", issue_valid, e_valid);
      check(busy == m_run[0], "R2 busy", busy, m_run);
      check(done == m_done[0], "R8 done", done, m_done);
      if (issue_valid && e_valid) begin
        check(issue_addr == e_addr[ADDR_W-1:0], "R5 addr", issue_addr, e_addr);
        for (int u = 0; u < NUM_FU; u++) begin
          check(fu_op[u*4 +: 4] == e_line[16 + u*7 +: 4], "R3 op", fu_op[u*4 +: 4], e_line[16 + u*7 +: 4]);
          check(fu_dst[u*3 +: 3] == e_line[20 + u*7 +: 3], "R3 dst", fu_dst[u*3 +: 3], e_line[20 + u*7 +: 3]);
        end
      end
      if (issue_valid) begin
        n_issue++;
        per_addr[issue_addr]++;
      end
    end
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr_line(input int a, input logic [LINE_W-1:0] d);
    @(negedge clk);
    host_line_we = 1; host_line_addr = 5'(a); host_line_data = d;
    @(negedge clk);
    host_line_we = 0;
  endtask

  task automatic wr_kreg(input int i, input int v);
    @(negedge clk);
    host_kreg_we = 1; host_kreg_idx = 2'(i); host_kreg_data = 8'(v);
    @(negedge clk);
    host_kreg_we = 0;
  endtask

  task automatic run(input int sa);
    n_issue = 0;
    for (int a = 0; a < LINES; a++) per_addr[a] = 0;
    @(negedge clk);
    start_i = 1; start_addr = 5'(sa);
    @(negedge clk);
    start_i = 0;
    for (int t = 0; t < 2000 && busy; t++) @(negedge clk);
  endtask

  initial begin
    logic [LINE_W-1:0] keep0;
    repeat (3) @(negedge clk);
    check(issue_valid == 0 && busy == 0 && done == 0, "R1 reset", {issue_valid, busy, done}, 0);
    rst_n = 1;
    for (int a = 0; a < LINES; a++) wr_line(a, mk(4, 0, 0, a));
    keep0 = mk(0, 0, 0, 100);
    wr_line(0, keep0);            wr_line(31, mk(0, 0, 0, 131));
    wr_line(2, mk(0, 0, 0, 2));   wr_line(3, mk(1, 0, 3, 3));
    wr_line(4, mk(1, 0, 0, 4));   wr_line(5, mk(1, 0, 1, 5));
    wr_line(8, mk(0, 0, 0, 8));   wr_line(9, mk(0, 0, 0, 9));
    wr_line(10, mk(2, 8, 2, 10)); wr_line(11, mk(2, 11, 0, 11));
    wr_line(14, mk(0, 0, 0, 14)); wr_line(15, mk(3, 14, 1, 15));
    wr_line(18, mk(0, 0, 0, 18)); wr_line(19, mk(2, 18, 1, 19));
    wr_line(20, mk(2, 18, 2, 20));
    wr_line(24, mk(0, 0, 0, 24));
    for (int a = 25; a <= 29; a++) wr_line(a, mk(2, 24, 1, a));
    wr_kreg(1, 4);
    wr_kreg(2, 9);

    run(2);  // R4
    check(n_issue == 6, "R4 total", n_issue, 6);
    check(per_addr[3] == 3, "R4 hold3", per_addr[3], 3);
    check(per_addr[4] == 1 && per_addr[5] == 1, "R4 hold0/1", per_addr[4] + per_addr[5], 2);
    check(done == 1 && busy == 0, "R8 stop", {done, busy}, 2);

    run(8);  // R5
    check(n_issue == 10, "R5 total", n_issue, 10);
    check(per_addr[8] == 3 && per_addr[11] == 1, "R5 jumps", per_addr[8], 3);

    run(14); // R6
    check(n_issue == 10, "R6 regcount", n_issue, 10);

    run(18); // R7
    check(n_issue == 15, "R7 nest", n_issue, 15);
    check(per_addr[19] == 6, "R7 inner", per_addr[19], 6);

    run(24); // R10
    check(n_issue == 92, "R10 overflow", n_issue, 92);

    // R2 wrap + R9 writes and start while busy, start held across stop edge
    n_issue = 0;
    for (int a = 0; a < LINES; a++) per_addr[a] = 0;
    @(negedge clk);
    start_i = 1; start_addr = 5'd31;
    @(negedge clk);
    host_line_we = 1; host_line_addr = 5'd0; host_line_data = mk(4, 0, 0, 7);
    host_kreg_we = 1; host_kreg_idx = 2'd1; host_kreg_data = 8'd0;
    start_addr = 5'd2;
    for (int t = 0; t < 100 && busy; t++) @(negedge clk);
    start_i = 0; host_line_we = 0; host_kreg_we = 0;
    check(per_addr[31] == 1 && per_addr[0] == 1, "R2 wrap", per_addr[0], 1);
    check(done == 1 && busy == 0, "R9 start at stop ignored", {done, busy}, 2);
    @(negedge clk);
    check(busy == 0 && issue_valid == 0, "R9 no restart", busy, 0);

    run(31); // line 0 and kreg1 must be untouched
    check(per_addr[0] == 1, "R9 line kept", per_addr[0], 1);
    run(14);
    check(n_issue == 10, "R9 kreg kept", n_issue, 10);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule